// File: doc/BRIEF.md
# Power island on/off sequencer

This block steps one switchable power island through its power-down and power-up sequences. It starts a sequence on a one-cycle request pulse. Each sequence drives these controls in order, with fixed settle waits between the steps:

- the island's sleep switch,
- a set of memory-bank power-down fields,
- the isolation clamp,
- the island reset,
- the island clock enable.

The wait lengths are given in microseconds and converted to clock cycles from a clock-frequency parameter. Two configuration pins select the kind of island:

- `cfg_has_switch` says whether the island has a top-level power switch. Without one, only the memory fields are sequenced.
- `cfg_has_clk` says whether the block manages the island's clock.

A boot pin tells the block that the island was already powered when the chip came out of reset. The block reports `busy`, a one-cycle `done`, the powered-off status, and an always-on flag.

All pins are plain control and status levels or pulses. No data flows through the block, so there is no valid/ready handshake. Requests are one-cycle pulses. A request that arrives while a sequence runs is dropped, not held. When more than one request is raised in the same cycle, shutdown wins over off, and off wins over on.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset with `boot_powered` low:
  - `sleep_en`, `iso_en` (with `cfg_has_switch` high) and `island_rst` are high.
  - Every `mem_pd` bit is 1.
  - `clk_en` and `busy` are low.
  - `powered_off` is high.
- R2: An accepted off request makes these changes, counted from the accepting edge E:
  - `sleep_en` rises at E.
  - All memory fields go to 11 at E+S.
  - `iso_en` rises at E+2S.
  - With `cfg_has_clk` high, `clk_en` falls at E+2S+L and `done` pulses there.
  - Without `cfg_has_clk`, `done` pulses at E+2S.
- R3: An accepted on request makes these changes, counted from the accepting edge E:
  - `sleep_en` falls at E.
  - All memory fields go to 00 at E+S.
  - `island_rst` rises at E+2S.
  - `iso_en` falls at E+2S+1.
  - `island_rst` falls at E+2S+2.
  - At E+2S+3, `clk_en` takes the value of `cfg_has_clk` and `done` pulses.
- R4: The short wait is S = max(1, CLK_KHZ*SETTLE_US/1000) cycles. The long wait is L = max(1, CLK_KHZ*CLKOFF_US/1000) cycles.
- R5: `mem_pd` holds NBANK two-bit fields, and bank b is bits [2b+1:2b]. The value 11 powers a bank down and 00 powers it up. All banks change on the same edge.
- R6: With `cfg_has_switch` low, `sleep_en` and `iso_en` stay low. The memory steps, the reset steps, the clock steps and all waits keep the timing of R2 and R3.
- R7: `powered_off` is the internal sleep state: it is 1 when the island is off, including for memory-only islands. It changes on the edge that starts a sequence.
- R8: A shutdown request starts the off sequence only when `powered_off` is 0. When the island is already off, a shutdown request changes no output and gives no `done`.
- R9: After reset with `boot_powered` and `cfg_has_switch` both high:
  - Sleep, isolation, reset and all memory fields are released.
  - `clk_en` and `always_on` both equal `cfg_has_clk`.
  - While `always_on` is set, an off request changes nothing and gives no `done`.
  - A shutdown request still powers the island off and clears `always_on`.
- R10: A request sampled while `busy` is high, including on the final step edge, is ignored.
- R11: A request for the state the island is already in gives a one-cycle `done` on the next edge and changes no other output.
- R12: Requests raised in the same cycle are ranked shutdown, then off, then on.
- R13: `busy` is high from the accepting edge through the final step edge. `done` rises on the edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_has_switch | input | 1 | Island has a top-level power switch |
| cfg_has_clk | input | 1 | Island clock is managed by the sequencer |
| boot_powered | input | 1 | Island is already powered when reset is released |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse (refused while always-on) |
| req_shutdown | input | 1 | Shutdown request pulse (powers down only if on) |
| sleep_en | output | 1 | Power switch sleep control, 1 = switch open |
| mem_pd | output | 2*NBANK | Memory bank power-down fields, 11 = down |
| iso_en | output | 1 | Isolation clamp enable |
| island_rst | output | 1 | Island reset, active high |
| clk_en | output | 1 | Island clock enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| powered_off | output | 1 | Island is off |
| always_on | output | 1 | Island was boot-powered with clocks; off requests refused |

## Verification
The collision of interest is between a sequence finishing and a new request arriving. On the final step edge the last control change and `done` occur, and the same edge samples any new request. The bench holds an off request across both the final edge of a power-up and the following edge. The scoreboard must show the first sample dropped and the off sequence starting exactly one edge later, with that start merged into the cycle where `done` falls. Simultaneous on and off requests are also raised, both while the island is off and while it is on, to check the ranking.

// File: rtl/pis_pkg.sv
package pis_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF_W1,
    ST_OFF_W2,
    ST_OFF_W3,
    ST_ON_W1,
    ST_ON_W2,
    ST_ON_ISO,
    ST_ON_RST,
    ST_ON_CLK
  } seq_state_t;

endpackage

// File: rtl/pis_delay.sv
module pis_delay #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pis_bank_field.sv
module pis_bank_field (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_up,
  input  logic       pd_set,
  input  logic       pd_clr,
  output logic [1:0] field
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field <= boot_up ? 2'b00 : 2'b11;
    end else if (pd_set) begin
      field <= 2'b11;
    end else if (pd_clr) begin
      field <= 2'b00;
    end
  end

endmodule

// File: rtl/pis_fsm.sv
module pis_fsm
  import pis_pkg::*;
#(
  parameter int unsigned   CW        = 8,
  parameter logic [CW-1:0] SETTLE_LD = '0,
  parameter logic [CW-1:0] CLKOFF_LD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_on,
  input  logic          cfg_has_clk,
  input  logic          req_on,
  input  logic          req_off,
  input  logic          req_sd,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          mem_set,
  output logic          mem_clr,
  output logic          sleep_r,
  output logic          iso_r,
  output logic          rst_r,
  output logic          clk_en,
  output logic          always_on,
  output logic          done,
  output logic          busy
);

  seq_state_t st;
  logic idle, sd_hit, off_hit, on_hit, go_off, go_on, ack;

  assign idle    = (st == ST_IDLE);
  assign sd_hit  = req_sd;
  assign off_hit = !req_sd && req_off;
  assign on_hit  = !req_sd && !req_off && req_on;

  assign go_off = idle && !sleep_r && (sd_hit || (off_hit && !always_on));
  assign go_on  = idle && on_hit && sleep_r;
  assign ack    = idle && ((off_hit && sleep_r) || (on_hit && !sleep_r));
  assign busy   = !idle;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LD;
    mem_set  = 1'b0;
    mem_clr  = 1'b0;
    case (st)
      ST_IDLE:   tmr_load = go_off || go_on;
      ST_OFF_W1: begin
        mem_set  = tmr_expired;
        tmr_load = tmr_expired;
      end
      ST_OFF_W2: begin
        tmr_load = tmr_expired && cfg_has_clk;
        tmr_val  = CLKOFF_LD;
      end
      ST_ON_W1: begin
        mem_clr  = tmr_expired;
        tmr_load = tmr_expired;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sleep_r   <= !boot_on;
      iso_r     <= !boot_on;
      rst_r     <= !boot_on;
      clk_en    <= boot_on && cfg_has_clk;
      always_on <= boot_on && cfg_has_clk;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go_off) begin
            sleep_r   <= 1'b1;
            always_on <= 1'b0;
            st        <= ST_OFF_W1;
          end else if (go_on) begin
            sleep_r <= 1'b0;
            st      <= ST_ON_W1;
          end else if (ack) begin
            done <= 1'b1;
          end
        end
        ST_OFF_W1: if (tmr_expired) st <= ST_OFF_W2;
        ST_OFF_W2: begin
          if (tmr_expired) begin
            iso_r <= 1'b1;
            if (cfg_has_clk) begin
              st <= ST_OFF_W3;
            end else begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end
          end
        end
        ST_OFF_W3: begin
          if (tmr_expired) begin
            clk_en <= 1'b0;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_ON_W1: if (tmr_expired) st <= ST_ON_W2;
        ST_ON_W2: begin
          if (tmr_expired) begin
            rst_r <= 1'b1;
            st    <= ST_ON_ISO;
          end
        end
        ST_ON_ISO: begin
          iso_r <= 1'b0;
          st    <= ST_ON_RST;
        end
        ST_ON_RST: begin
          rst_r <= 1'b0;
          st    <= ST_ON_CLK;
        end
        ST_ON_CLK: begin
          clk_en <= cfg_has_clk;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq #(
  parameter int unsigned NBANK     = 4,
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned SETTLE_US = 20,
  parameter int unsigned CLKOFF_US = 20000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_has_switch,
  input  logic               cfg_has_clk,
  input  logic               boot_powered,
  input  logic               req_on,
  input  logic               req_off,
  input  logic               req_shutdown,
  output logic               sleep_en,
  output logic [2*NBANK-1:0] mem_pd,
  output logic               iso_en,
  output logic               island_rst,
  output logic               clk_en,
  output logic               busy,
  output logic               done,
  output logic               powered_off,
  output logic               always_on
);

  localparam longint unsigned SETTLE_RAW = (longint'(CLK_KHZ) * SETTLE_US) / 1000;
  localparam longint unsigned CLKOFF_RAW = (longint'(CLK_KHZ) * CLKOFF_US) / 1000;
  localparam longint unsigned SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam longint unsigned CLKOFF_CYC = (CLKOFF_RAW < 1) ? 1 : CLKOFF_RAW;
  localparam longint unsigned MAX_CYC    = (SETTLE_CYC > CLKOFF_CYC) ? SETTLE_CYC : CLKOFF_CYC;
  localparam int unsigned     CW         = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0]   SETTLE_LD  = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0]   CLKOFF_LD  = CW'(CLKOFF_CYC - 1);

  logic          boot_on;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  logic          mem_set, mem_clr;
  logic          sleep_r, iso_r;

  assign boot_on = boot_powered && cfg_has_switch;

  pis_delay #(.CW(CW)) delay_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pis_fsm #(
    .CW        (CW),
    .SETTLE_LD (SETTLE_LD),
    .CLKOFF_LD (CLKOFF_LD)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_on     (boot_on),
    .cfg_has_clk (cfg_has_clk),
    .req_on      (req_on),
    .req_off     (req_off),
    .req_sd      (req_shutdown),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .mem_set     (mem_set),
    .mem_clr     (mem_clr),
    .sleep_r     (sleep_r),
    .iso_r       (iso_r),
    .rst_r       (island_rst),
    .clk_en      (clk_en),
    .always_on   (always_on),
    .done        (done),
    .busy        (busy)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pis_bank_field field_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .boot_up (boot_on),
      .pd_set  (mem_set),
      .pd_clr  (mem_clr),
      .field   (mem_pd[2*b +: 2])
    );
  end

  assign sleep_en    = sleep_r && cfg_has_switch;
  assign iso_en      = iso_r && cfg_has_switch;
  assign powered_off = sleep_r;

endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
  parameter int unsigned NBANK = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NBANK-1:0] mem_pd,
  input logic               iso_en,
  input logic               island_rst,
  input logic               clk_en,
  input logic               busy,
  input logic               done,
  input logic               powered_off,
  input logic               always_on
);

  assert_done_at_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_off_via_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered_off) |-> busy);

  assert_iso_drop_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> island_rst);

  assert_iso_after_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_en) |-> (mem_pd == '1));

  assert_clk_gate_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> (mem_pd == '1));

  assert_banks_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pd == '0) || (mem_pd == '1));

  assert_pinned_is_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    always_on |-> !powered_off);

endmodule

bind pwr_island_seq pis_checker #(.NBANK(NBANK)) checker_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_pd      (mem_pd),
  .iso_en      (iso_en),
  .island_rst  (island_rst),
  .clk_en      (clk_en),
  .busy        (busy),
  .done        (done),
  .powered_off (powered_off),
  .always_on   (always_on)
);

// File: tb/pwr_island_seq_tb_top.sv
module pwr_island_seq_tb_top;

  localparam int NB   = 4;
  localparam int MW   = 2 * NB;
  localparam int VW   = MW + 5;
  localparam int KHZ  = 1000;
  localparam int S_US = 3;
  localparam int L_US = 10;
  localparam int S    = (KHZ * S_US / 1000 < 1) ? 1 : KHZ * S_US / 1000;
  localparam int L    = (KHZ * L_US / 1000 < 1) ? 1 : KHZ * L_US / 1000;

  typedef struct {
    int             t;
    logic [VW-1:0]  v;
    string          tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_has_switch = 1'b1, cfg_has_clk = 1'b1, boot_powered = 1'b0;
  logic req_on = 1'b0, req_off = 1'b0, req_shutdown = 1'b0;
  logic sleep_en, iso_en, island_rst, clk_en, busy, done, powered_off, always_on;
  logic [MW-1:0] mem_pd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  ev_t exp_q[$];
  logic [VW-1:0] last_v, prev_v;
  bit m_sl, m_iso, m_rst, m_clk, m_mem;

  pwr_island_seq #(
    .NBANK(NB), .CLK_KHZ(KHZ), .SETTLE_US(S_US), .CLKOFF_US(L_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_has_switch(cfg_has_switch),
    .cfg_has_clk(cfg_has_clk), .boot_powered(boot_powered),
    .req_on(req_on), .req_off(req_off), .req_shutdown(req_shutdown),
    .sleep_en(sleep_en), .mem_pd(mem_pd), .iso_en(iso_en),
    .island_rst(island_rst), .clk_en(clk_en), .busy(busy), .done(done),
    .powered_off(powered_off), .always_on(always_on)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [VW-1:0] obs();
    return {sleep_en, iso_en, island_rst, clk_en, done, mem_pd};
  endfunction

  function automatic logic [VW-1:0] model(bit d);
    return {m_sl & cfg_has_switch, m_iso & cfg_has_switch, m_rst, m_clk, d, {MW{m_mem}}};
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic ev(int t, bit d, string tag);
    logic [VW-1:0] v;
    ev_t e;
    v = model(d);
    if (exp_q.size() > 0 && exp_q[$].t == t) begin
      exp_q[$].v = v;
    end else if (v !== last_v) begin
      e.t = t; e.v = v; e.tag = tag;
      exp_q.push_back(e);
    end
    last_v = v;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      logic [VW-1:0] cur;
      cur = obs();
      if (cur !== prev_v) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected change at cyc %0d: actual=%0h expected=no change", cyc, cur);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (e.t != cyc || e.v !== cur) begin
            fails++;
            $display("FAIL %s: actual=cyc %0d val %0h expected=cyc %0d val %0h",
                     e.tag, cyc, cur, e.t, e.v);
          end
        end
      end
      prev_v = cur;
    end
  end

  task automatic exp_off(int e0, string tag);
    m_sl = 1'b1;  ev(e0, 1'b0, tag);
    m_mem = 1'b1; ev(e0 + S, 1'b0, tag);
    m_iso = 1'b1;
    if (cfg_has_clk) begin
      ev(e0 + 2*S, 1'b0, tag);
      m_clk = 1'b0;
      ev(e0 + 2*S + L, 1'b1, tag);
      ev(e0 + 2*S + L + 1, 1'b0, tag);
    end else begin
      ev(e0 + 2*S, 1'b1, tag);
      ev(e0 + 2*S + 1, 1'b0, tag);
    end
  endtask

  task automatic exp_on(int e0, string tag);
    m_sl = 1'b0;  ev(e0, 1'b0, tag);
    m_mem = 1'b0; ev(e0 + S, 1'b0, tag);
    m_rst = 1'b1; ev(e0 + 2*S, 1'b0, tag);
    m_iso = 1'b0; ev(e0 + 2*S + 1, 1'b0, tag);
    m_rst = 1'b0; ev(e0 + 2*S + 2, 1'b0, tag);
    m_clk = cfg_has_clk; ev(e0 + 2*S + 3, 1'b1, tag);
    ev(e0 + 2*S + 4, 1'b0, tag);
  endtask

  task automatic exp_ack(int e0, string tag);
    ev(e0, 1'b1, tag);
    ev(e0 + 1, 1'b0, tag);
  endtask

  task automatic fire(bit on, bit off, bit sd, output int e0);
    @(posedge clk); #1;
    req_on = on; req_off = off; req_shutdown = sd;
    e0 = cyc + 1;
  endtask

  task automatic drop_req();
    @(posedge clk); #1;
    req_on = 1'b0; req_off = 1'b0; req_shutdown = 1'b0;
  endtask

  task automatic wait_neg(int t);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit sw, bit ck, bit boot);
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_has_switch = sw; cfg_has_clk = ck; boot_powered = boot;
    exp_q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    if (boot && sw) begin
      m_sl = 0; m_iso = 0; m_rst = 0; m_mem = 0; m_clk = ck;
    end else begin
      m_sl = 1; m_iso = 1; m_rst = 1; m_mem = 1; m_clk = 0;
    end
    last_v = model(1'b0);
    prev_v = obs();
    mon_en = 1'b1;
  endtask

  initial begin
    int e0, e1, fin;

    // ---- switched island with clock, cold boot
    do_reset(1'b1, 1'b1, 1'b0);
    chk(sleep_en == 1 && iso_en == 1 && island_rst == 1, "R1 controls asserted",
        {sleep_en, iso_en, island_rst}, 3'b111);
    chk(mem_pd == '1, "R1 mem down", mem_pd, {MW{1'b1}});
    chk(clk_en == 0 && busy == 0 && powered_off == 1, "R1 status",
        {clk_en, busy, powered_off}, 3'b001);

    // power up, R3 / R4 / R5 timing via scoreboard
    fire(1, 0, 0, e0); exp_on(e0, "R3 on sequence"); drop_req();
    wait_neg(e0);
    chk(busy == 1, "R13 busy after accept", busy, 1);
    chk(powered_off == 0, "R7 status on at accept", powered_off, 0);
    wait_neg(e0 + 2*S + 2);
    chk(busy == 1, "R13 busy before last step", busy, 1);
    wait_neg(e0 + 2*S + 3);
    chk(busy == 0 && done == 1, "R13 busy falls with done", {busy, done}, 2'b01);
    idle_wait(4);

    // same-state request, R11
    fire(1, 0, 0, e0); exp_ack(e0, "R11 on while on"); drop_req();
    idle_wait(4);

    // power down with a busy-time on request ignored, R2 / R10
    fire(0, 1, 0, e0); exp_off(e0, "R2 off sequence"); drop_req();
    wait_neg(e0 + 1);
    fire(1, 0, 0, e1); drop_req();
    wait_neg(e0 + 2*S + L + 3);
    chk(powered_off == 1, "R10 on ignored while busy", powered_off, 1);

    // coincidence: off held across final edge of power up, R10
    fire(1, 0, 0, e0); exp_on(e0, "R10 on before collision"); drop_req();
    fin = e0 + 2*S + 3;
    while (cyc != fin - 1) @(posedge clk);
    #1;
    req_off = 1'b1;
    exp_off(fin + 1, "R10 off after final edge");
    @(posedge clk); #1;
    @(posedge clk); #1;
    req_off = 1'b0;
    wait_neg(fin + 1 + 2*S + L + 3);
    chk(powered_off == 1, "R10 second sample accepted", powered_off, 1);

    // shutdown when off: nothing, R8
    fire(0, 0, 1, e0); drop_req();
    idle_wait(6);
    chk(powered_off == 1 && done == 0, "R8 shutdown while off", {powered_off, done}, 2'b10);

    // priority, R12: on+off while off -> off wins -> ack only
    fire(1, 1, 0, e0); exp_ack(e0, "R12 off outranks on"); drop_req();
    idle_wait(4);
    fire(1, 0, 0, e0); exp_on(e0, "R3 on again"); drop_req();
    idle_wait(2*S + 8);
    // shutdown+on while on -> shutdown wins, R8 / R12
    fire(1, 0, 1, e0); exp_off(e0, "R12 shutdown outranks on"); drop_req();
    idle_wait(2*S + L + 6);
    chk(powered_off == 1, "R8 shutdown while on", powered_off, 1);

    // ---- memory-only island, R6
    do_reset(1'b0, 1'b1, 1'b0);
    chk(sleep_en == 0 && iso_en == 0 && powered_off == 1, "R6 reset memory-only",
        {sleep_en, iso_en, powered_off}, 3'b001);
    fire(1, 0, 0, e0); exp_on(e0, "R6 on memory-only"); drop_req();
    wait_neg(e0);
    chk(powered_off == 0, "R7 memory-only status on", powered_off, 0);
    idle_wait(2*S + 6);
    fire(0, 1, 0, e0); exp_off(e0, "R6 off memory-only"); drop_req();
    idle_wait(2*S + L + 6);
    chk(powered_off == 1, "R7 memory-only status off", powered_off, 1);

    // ---- boot powered with clock, R9
    do_reset(1'b1, 1'b1, 1'b1);
    chk(sleep_en == 0 && iso_en == 0 && island_rst == 0 && mem_pd == '0,
        "R9 boot released", {sleep_en, iso_en, island_rst, mem_pd}, 0);
    chk(clk_en == 1 && always_on == 1 && powered_off == 0, "R9 boot pinned",
        {clk_en, always_on, powered_off}, 3'b110);
    fire(0, 1, 0, e0); drop_req();
    idle_wait(2*S + L + 4);
    chk(powered_off == 0 && always_on == 1, "R9 off refused", {powered_off, always_on}, 2'b01);
    fire(0, 0, 1, e0); exp_off(e0, "R9 shutdown pinned island"); drop_req();
    idle_wait(2*S + L + 4);
    chk(powered_off == 1 && always_on == 0, "R9 shutdown clears pin",
        {powered_off, always_on}, 2'b10);

    // ---- boot powered, no clock: short off path, R2 / R9
    do_reset(1'b1, 1'b0, 1'b1);
    chk(always_on == 0 && clk_en == 0, "R9 no clock not pinned", {always_on, clk_en}, 0);
    fire(0, 1, 0, e0); exp_off(e0, "R2 off without clock"); drop_req();
    wait_neg(e0 + 2*S);
    chk(done == 1, "R4 no-clock done at 2S", done, 1);
    idle_wait(6);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule